// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flag Update

This block is the execute-stage arithmetic and logic unit of a 32-bit processor datapath. Each cycle it takes two operands, the second already passed through the barrel shifter, together with the shifter's carry-out, a 4-bit operation code, a request to update the condition flags and the current flag values. One clock later it presents the result, a write strobe for the destination register and the next value of the four condition flags.

The operation code selects one of sixteen data-processing operations. These fall into three classes. The arithmetic class covers add, add with carry, subtract, reverse subtract and their carry-using forms. The logical class covers AND, exclusive OR, OR, bit clear, move and move-inverted. The compare class covers test, test-equivalence, compare and compare-negated. Which flags change depends on the class. Compare operations always write the flags and never write a register. All other operations write a register and change the flags only on request.

The reset input is asserted asynchronously. It is released through an internal two-stage synchronizer, so the outputs stay cleared for two clocks after the input rises.

Top module: `dp_alu`

## Requirements
- R1: While the reset is active, and for two clocks after it is released, `result`, `result_we` and `flags_out` are zero.
- R2: The opcode values are as follows. 4'h2 gives op_a-op_b and 4'h3 gives op_b-op_a. 4'h4 gives op_a+op_b. 4'h5 gives op_a+op_b+C. 4'h6 gives op_a-op_b-(1-C) and 4'h7 gives op_b-op_a-(1-C). 4'hA (compare) and 4'hB (compare-negated) compute op_a-op_b and op_a+op_b. All results are taken modulo 2^32, and C is `flags_in` bit 1.
- R3: The logical opcodes are as follows. 4'h0 and 4'h8 give op_a AND op_b. 4'h1 and 4'h9 give op_a XOR op_b. 4'hC gives op_a OR op_b. 4'hD gives op_b. 4'hE gives op_a AND NOT op_b. 4'hF gives NOT op_b.
- R4: `result_we` is 0 for opcodes 4'h8 to 4'hB and 1 for every other opcode.
- R5: When `set_flags` is 0 and the opcode is not 4'h8 to 4'hB, `flags_out` equals `flags_in`.
- R6: Opcodes 4'h8 to 4'hB update the flags whether or not `set_flags` is set.
- R7: When an arithmetic operation updates the flags, C is the carry out of bit 31 of the internal addition. For subtraction this means C is 1 when there is no borrow, that is, when the minuend is greater than or equal to the subtrahend as unsigned numbers. V is 1 when the two's-complement result overflows.
- R8: On any flag update, N is bit 31 of the result and Z is 1 when all 32 result bits are zero.
- R9: On a flag update by a logical-class opcode, V keeps its `flags_in` value. C takes `shift_carry` when `shift_used` is 1 and otherwise keeps its `flags_in` value.
- R10: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Data-processing operation code |
| set_flags | input | 1 | Request to update flags (non-compare ops) |
| shift_used | input | 1 | A shift was applied to op_b |
| shift_carry | input | 1 | Carry-out of the shifter |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second (shifted) operand |
| flags_in | input | 4 | Current flags {N,Z,C,V} (bit 3 = N, bit 0 = V) |
| result | output | 32 | Operation result |
| result_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The operand pairs are chosen to sit on the arithmetic edges. They include signed overflow in both directions, an unsigned wrap to zero, subtraction with and without borrow, and the carry-in forms with C both set and clear, so that the carry sense and the V logic can each be told apart. The logical opcodes are run with `shift_used` both set and clear and with preset C and V values, which separates a correctly kept flag from one that is cleared or overwritten. Compare opcodes with `set_flags` low and plain opcodes with `set_flags` low show the forced update and the suppressed update respectively. Directed steps cover reset, including an asynchronous reset in the middle of a run, and the one-cycle latency.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ARITH = 2'd1
  } alu_class_e;

  // Compare group occupies codes 8..11
  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic alu_class_e op_class(input logic [3:0] op);
    alu_class_e cls;
    case (op)
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB: cls = CLS_ARITH;
      default:                                         cls = CLS_LOGIC;
    endcase
    return cls;
  endfunction

endpackage

// File: rtl/dp_alu_rst_sync.sv
module dp_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   wide;

  // Operand steering: subtraction is x + ~y + 1, carry forms take C
  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    case (alu_op_e'(op))
      OP_SUB, OP_CMP: begin x = a; y = ~b; cin = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
      OP_ADD, OP_CMN: begin x = a; y = b;  cin = 1'b0; end
      OP_ADC:         begin x = a; y = b;  cin = c_in; end
      OP_SBC:         begin x = a; y = ~b; cin = c_in; end
      OP_RSC:         begin x = b; y = ~a; cin = c_in; end
      default:        begin x = a; y = b;  cin = 1'b0; end
    endcase
  end

  always_comb begin
    wide  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum   = wide[WIDTH-1:0];
    c_out = wide[WIDTH];
    ovf   = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
  end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flagcalc.sv
module dp_alu_flagcalc
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic             set_req,
  input  logic             shift_used,
  input  logic             shift_carry,
  input  logic [WIDTH-1:0] res,
  input  logic             add_c,
  input  logic             add_v,
  input  alu_flags_t       cur,
  output alu_flags_t       nxt,
  output logic             we
);
  logic is_cmp;
  logic upd;

  always_comb begin
    is_cmp = op_is_compare(op);
    upd    = set_req | is_cmp;
    we     = ~is_cmp;
    nxt    = cur;
    if (upd) begin
      nxt.n = res[WIDTH-1];
      nxt.z = (res == '0);
      if (op_class(op) == CLS_ARITH) begin
        nxt.c = add_c;
        nxt.v = add_v;
      end else begin
        nxt.c = shift_used ? shift_carry : cur.c;
        nxt.v = cur.v;
      end
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic             shift_used,
  input  logic             shift_carry,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_out
);
  localparam int SYNC_STAGES = 2;

  logic             rst_sync_n;
  logic [WIDTH-1:0] arith_res, logic_res;
  logic             arith_c, arith_v;
  logic [WIDTH-1:0] res_d, res_q;
  logic             we_d, we_q;
  alu_flags_t       flg_cur, flg_d, flg_q;

  assign flg_cur = alu_flags_t'(flags_in);

  dp_alu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dp_alu_addsub #(.WIDTH(WIDTH)) u_add (
    .op    (opcode),
    .a     (op_a),
    .b     (op_b),
    .c_in  (flg_cur.c),
    .sum   (arith_res),
    .c_out (arith_c),
    .ovf   (arith_v)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_log (
    .op  (opcode),
    .a   (op_a),
    .b   (op_b),
    .res (logic_res)
  );

  always_comb begin
    res_d = (op_class(opcode) == CLS_ARITH) ? arith_res : logic_res;
  end

  dp_alu_flagcalc #(.WIDTH(WIDTH)) u_flg (
    .op          (opcode),
    .set_req     (set_flags),
    .shift_used  (shift_used),
    .shift_carry (shift_carry),
    .res         (res_d),
    .add_c       (arith_c),
    .add_v       (arith_v),
    .cur         (flg_cur),
    .nxt         (flg_d),
    .we          (we_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      we_q  <= 1'b0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      we_q  <= we_d;
      flg_q <= flg_d;
    end
  end

  assign result    = res_q;
  assign result_we = we_q;
  assign flags_out = flg_q;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       opcode,
  input logic             set_flags,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       flags_in,
  input logic [WIDTH-1:0] result,
  input logic             result_we,
  input logic [3:0]       flags_out
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  function automatic logic is_logic_op(input logic [3:0] op);
    return (op == 4'h0) || (op == 4'h1) || (op == 4'h8) || (op == 4'h9) ||
           (op[3:2] == 2'b11);
  endfunction

  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(opcode[3:2] == 2'b10) |-> !result_we);

  a_r4_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(opcode[3:2] != 2'b10) |-> result_we);

  a_r5_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(!set_flags && opcode[3:2] != 2'b10) |-> flags_out == $past(flags_in));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(set_flags || opcode[3:2] == 2'b10) |-> flags_out[2] == (result == '0));

  a_r8_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(set_flags || opcode[3:2] == 2'b10) |-> flags_out[3] == result[WIDTH-1]);

  a_r9_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(is_logic_op(opcode)) |-> flags_out[0] == $past(flags_in[0]));

  a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(opcode == 4'h4) |-> result == $past(op_a + op_b));
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .opcode    (opcode),
  .set_flags (set_flags),
  .op_a      (op_a),
  .op_b      (op_b),
  .flags_in  (flags_in),
  .result    (result),
  .result_we (result_we),
  .flags_out (flags_out)
);

// File: tb/dp_alu_tb_top.sv
`timescale 1ns/1ps
module dp_alu_tb_top;

  typedef struct packed {
    logic [3:0]  op;
    logic        sf;
    logic        shu;
    logic        shc;
    logic [3:0]  fi;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fo;
  } vec_t;

  localparam int NVEC = 20;
  // flags are {N,Z,C,V}
  localparam vec_t TBL [NVEC] = '{
    '{4'h4,1'b1,1'b0,1'b0,4'b0000,32'h7FFFFFFF,32'h00000001,32'h80000000,1'b1,4'b1001}, // R7 add overflow
    '{4'h4,1'b1,1'b0,1'b0,4'b0000,32'hFFFFFFFF,32'h00000001,32'h00000000,1'b1,4'b0110}, // R7 carry, R8 zero
    '{4'h2,1'b1,1'b0,1'b0,4'b0000,32'h00000005,32'h00000003,32'h00000002,1'b1,4'b0010}, // R7 no borrow
    '{4'h2,1'b1,1'b0,1'b0,4'b0000,32'h00000003,32'h00000005,32'hFFFFFFFE,1'b1,4'b1000}, // R7 borrow
    '{4'h3,1'b1,1'b0,1'b0,4'b0000,32'h00000003,32'h00000005,32'h00000002,1'b1,4'b0010}, // R2 reverse
    '{4'h5,1'b1,1'b0,1'b0,4'b0010,32'h00000001,32'h00000002,32'h00000004,1'b1,4'b0000}, // R2 adc
    '{4'h6,1'b1,1'b0,1'b0,4'b0000,32'h00000005,32'h00000003,32'h00000001,1'b1,4'b0010}, // R2 sbc
    '{4'h7,1'b1,1'b0,1'b0,4'b0010,32'h00000003,32'h00000005,32'h00000002,1'b1,4'b0010}, // R2 rsc
    '{4'hA,1'b0,1'b0,1'b0,4'b0000,32'h00000005,32'h00000005,32'h00000000,1'b0,4'b0110}, // R6 cmp
    '{4'hB,1'b0,1'b0,1'b0,4'b1111,32'h80000000,32'h80000000,32'h00000000,1'b0,4'b0111}, // R6 cmn
    '{4'h8,1'b0,1'b0,1'b0,4'b0011,32'h000000F0,32'h0000000F,32'h00000000,1'b0,4'b0111}, // R9 tst keep
    '{4'h9,1'b0,1'b1,1'b1,4'b0000,32'h80000000,32'h00000000,32'h80000000,1'b0,4'b1010}, // R9 teq shc
    '{4'h0,1'b1,1'b1,1'b0,4'b0001,32'hFF00FF00,32'h0FF00FF0,32'h0F000F00,1'b1,4'b0001}, // R3 and
    '{4'h1,1'b0,1'b0,1'b0,4'b1010,32'hFFFF0000,32'h0000FFFF,32'hFFFFFFFF,1'b1,4'b1010}, // R5 eor
    '{4'hC,1'b1,1'b0,1'b0,4'b0000,32'h00000000,32'h00000000,32'h00000000,1'b1,4'b0100}, // R3 orr
    '{4'hD,1'b1,1'b1,1'b0,4'b0110,32'h12345678,32'h80000000,32'h80000000,1'b1,4'b1000}, // R3 mov
    '{4'hE,1'b0,1'b0,1'b0,4'b0101,32'hFFFFFFFF,32'h0000FFFF,32'hFFFF0000,1'b1,4'b0101}, // R3 bic
    '{4'hF,1'b1,1'b0,1'b0,4'b0011,32'h00000000,32'hFFFFFFFF,32'h00000000,1'b1,4'b0111}, // R3 mvn
    '{4'h4,1'b0,1'b0,1'b0,4'b1001,32'h00000001,32'h00000001,32'h00000002,1'b1,4'b1001}, // R5 add keep
    '{4'h2,1'b1,1'b0,1'b0,4'b0000,32'h80000000,32'h00000001,32'h7FFFFFFF,1'b1,4'b0011}  // R7 sub overflow
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic        set_flags, shift_used, shift_carry;
  logic [31:0] op_a, op_b;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  int n_checks;
  int n_errors;
  bit done;

  dp_alu #(.WIDTH(32)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .set_flags   (set_flags),
    .shift_used  (shift_used),
    .shift_carry (shift_carry),
    .op_a        (op_a),
    .op_b        (op_b),
    .flags_in    (flags_in),
    .result      (result),
    .result_we   (result_we),
    .flags_out   (flags_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual {res,we,flags}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opcode      = v.op;
    set_flags   = v.sf;
    shift_used  = v.shu;
    shift_carry = v.shc;
    flags_in    = v.fi;
    op_a        = v.a;
    op_b        = v.b;
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    check("R1 reset state", {result, result_we, flags_out}, 38'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 held during sync release", {result, result_we, flags_out}, 38'h0);
    repeat (2) @(negedge clk);

    // main table
    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8/R9 vector %0d", i),
            {result, result_we, flags_out},
            {TBL[i].res, TBL[i].we, TBL[i].fo});
    end

    // R10: output holds until the next rising edge
    drive(TBL[1]);
    @(negedge clk);
    drive(TBL[2]);
    #1;
    check("R10 latency hold", {result, result_we, flags_out},
          {TBL[1].res, TBL[1].we, TBL[1].fo});
    @(negedge clk);
    check("R10 latency update", {result, result_we, flags_out},
          {TBL[2].res, TBL[2].we, TBL[2].fo});

    // R6: compare with set_flags low still updates carry (3 >= 3 -> C=1, Z=1)
    drive('{4'hA,1'b0,1'b0,1'b0,4'b1000,32'h3,32'h3,32'h0,1'b0,4'b0110});
    @(negedge clk);
    check("R6 compare forced update", {result, result_we, flags_out},
          {32'h0, 1'b0, 4'b0110});

    // R1: asynchronous reset mid-run clears outputs without a clock edge
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", {result, result_we, flags_out}, 38'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule